// File: doc/BRIEF.md
# Shadow Memory Region Address Router

This block steers every processor memory request to its target in a legacy PC memory map. The three possible targets are system RAM, the BIOS ROM, and unclaimed, which leaves the access to the bus. A request carries a 36-bit address and a write flag. One clock after the request is accepted, the block returns a registered decision. The decision holds the target, a flag that marks a discarded ROM write, and the offset into the RAM backing store.

The window from 0xC0000 to 0xFFFFF is the shadow area. It is divided into thirteen segments. Each segment has its own read-enable bit and its own write-enable bit. A read and a write to the same address can therefore reach different targets. This supports two uses:
- reading from ROM while writing into RAM, to copy the ROM contents;
- reading from RAM while writes go to ROM, to run from the shadow copy.

The low RAM region, the legacy video hole, extended memory below 4 GiB and memory remapped above 4 GiB are all resolved in a single decoder. The memory sizes are set in MiB through a small configuration write port.

Top module: `shadow_router`

## Requirements
- R1: An address below 0xA0000 decodes to RAM (target code 1) with offset equal to the address.
- R2: An address from 0xA0000 to 0xBFFFF decodes to unclaimed (target code 0) with offset 0.
- R3: Shadow segment i (0..11) covers 0xC0000 + i·0x4000 for 16 KiB. Segment 12 covers 0xF0000 to 0xFFFFF. Bit i of the read-enable register steers reads, and bit i of the write-enable register steers writes. A set bit gives RAM with offset equal to the address. A clear bit gives ROM (target code 2) with offset 0. All four combinations of the two bits per segment are honoured.
- R4: `dec_rom_write` is 1 exactly when a write hits a shadow segment whose write-enable bit is clear. It is 0 for every other decision.
- R5: An address from 0x100000 up to min(low_mb, 4096)·2^20 − 1 decodes to RAM with offset equal to the address.
- R6: An address from 2^32 up to 2^32 + high_mb·2^20 − 1 decodes to RAM. The offset is min(low_mb, 4096)·2^20 + address − 2^32.
- R7: Any address outside R1, R2, R3, R5 and R6 decodes to unclaimed with offset 0.
- R8: After reset, all enable bits are 0, both sizes are 0, and `dec_valid` is 0.
- R9: `req_ready` equals `!dec_valid || dec_ready`. A request accepted at one clock edge presents its decision from the next edge on. The decision holds unchanged while `dec_valid` is 1 and `dec_ready` is 0.
- R10: A configuration write sets a register according to `cfg_sel`:
  - 0: read-enable bits 12:0;
  - 1: write-enable bits 12:0;
  - 2: low_mb;
  - 3: high_mb.

  The new value applies from the next accepted request onward. A request accepted in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 36 | Request address |
| req_write | input | 1 | 1 for write, 0 for read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_data | input | 16 | Configuration write data |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_target | output | 2 | 0 unclaimed, 1 RAM, 2 ROM |
| dec_rom_write | output | 1 | Write to ROM, to be discarded |
| dec_offset | output | 36 | RAM backing offset |

## Verification
An internal fault shows up on the decision that follows the next accepted request. Each fault has its own signature:
- A wrong enable bit sends exactly one segment and one access type to the wrong target.
- A wrong size register moves the upper edge of a RAM range.
- A wrong size register also shifts every remapped high offset.

For these reasons the bench probes both edges of every range, and it reads and writes every segment under complementary enable patterns. Handshake faults appear in the very cycle they occur, either as a dropped or duplicated `dec_valid` or as a decision that changes while stalled.

// File: rtl/shadow_router_pkg.sv
package shadow_router_pkg;
    localparam int ADDR_W = 36;

    typedef enum logic [1:0] {
        TGT_BUS = 2'd0,
        TGT_RAM = 2'd1,
        TGT_ROM = 2'd2
    } target_e;

    localparam logic [ADDR_W-1:0] HOLE_BASE   = 36'h0_000A_0000;
    localparam logic [ADDR_W-1:0] SHADOW_BASE = 36'h0_000C_0000;
    localparam logic [ADDR_W-1:0] EXT_BASE    = 36'h0_0010_0000;
    localparam logic [ADDR_W-1:0] FOUR_G      = 36'h1_0000_0000;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs #(
    parameter int NUM_SEG = 13,
    parameter int SZ_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [15:0]        cfg_data,
    output logic [NUM_SEG-1:0] rd_en,
    output logic [NUM_SEG-1:0] wr_en,
    output logic [SZ_W-1:0]    low_mb,
    output logic [SZ_W-1:0]    high_mb
);
    typedef struct packed {
        logic [NUM_SEG-1:0] rd_en;
        logic [NUM_SEG-1:0] wr_en;
        logic [SZ_W-1:0]    low_mb;
        logic [SZ_W-1:0]    high_mb;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            unique case (cfg_sel)
                2'd0: cfg_d.rd_en   = cfg_data[NUM_SEG-1:0];
                2'd1: cfg_d.wr_en   = cfg_data[NUM_SEG-1:0];
                2'd2: cfg_d.low_mb  = cfg_data[SZ_W-1:0];
                default: cfg_d.high_mb = cfg_data[SZ_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign rd_en   = cfg_q.rd_en;
    assign wr_en   = cfg_q.wr_en;
    assign low_mb  = cfg_q.low_mb;
    assign high_mb = cfg_q.high_mb;

    // Registers only move on a configuration strobe
    assert_cfg_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(rd_en) && $stable(wr_en) && $stable(low_mb) && $stable(high_mb)));
endmodule

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
    import shadow_router_pkg::*;
#(
    parameter int NUM_SEG = 13,
    parameter int SZ_W    = 16
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               write,
    input  logic [NUM_SEG-1:0] rd_en,
    input  logic [NUM_SEG-1:0] wr_en,
    input  logic [SZ_W-1:0]    low_mb,
    input  logic [SZ_W-1:0]    high_mb,
    output target_e            target,
    output logic               rom_write,
    output logic [ADDR_W-1:0]  offset
);
    localparam int EW         = ADDR_W + 1;
    localparam int SMALL_SEGS = NUM_SEG - 1;
    localparam int SEG_LG     = 14;
    localparam int IDX_W      = $clog2(NUM_SEG);
    localparam int MB_LG      = 20;
    localparam logic [SZ_W-1:0] LOW_CAP = SZ_W'(4096);
    localparam logic [EW-1:0] HOLE_E   = EW'(HOLE_BASE);
    localparam logic [EW-1:0] SHADOW_E = EW'(SHADOW_BASE);
    localparam logic [EW-1:0] TOPSEG_E = EW'(SHADOW_BASE) + (EW'(SMALL_SEGS) << SEG_LG);
    localparam logic [EW-1:0] EXT_E    = EW'(EXT_BASE);
    localparam logic [EW-1:0] FOURG_E  = EW'(FOUR_G);

    logic [EW-1:0]    addr_e, low_end, high_end, seg_off;
    logic [SZ_W-1:0]  low_lim;
    logic [IDX_W-1:0] seg_idx;
    logic             en_bit;

    always_comb begin
        target    = TGT_BUS;
        rom_write = 1'b0;
        offset    = '0;
        addr_e    = {1'b0, addr};
        low_lim   = (low_mb > LOW_CAP) ? LOW_CAP : low_mb;
        low_end   = EW'(low_lim) << MB_LG;
        high_end  = FOURG_E + (EW'(high_mb) << MB_LG);
        seg_off   = addr_e - SHADOW_E;
        seg_idx   = (addr_e < TOPSEG_E) ? IDX_W'(seg_off >> SEG_LG) : IDX_W'(SMALL_SEGS);
        en_bit    = write ? wr_en[seg_idx] : rd_en[seg_idx];

        if (addr_e < HOLE_E) begin
            target = TGT_RAM;
            offset = addr;
        end else if (addr_e < SHADOW_E) begin
            target = TGT_BUS;
        end else if (addr_e < EXT_E) begin
            if (en_bit) begin
                target = TGT_RAM;
                offset = addr;
            end else begin
                target    = TGT_ROM;
                rom_write = write;
            end
        end else if (addr_e < FOURG_E) begin
            if (addr_e < low_end) begin
                target = TGT_RAM;
                offset = addr;
            end
        end else if (addr_e < high_end) begin
            target = TGT_RAM;
            offset = ADDR_W'(low_end + addr_e - FOURG_E);
        end
    end
endmodule

// File: rtl/shadow_router.sv
module shadow_router
    import shadow_router_pkg::*;
#(
    parameter int NUM_SEG = 13,
    parameter int SZ_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [35:0]       req_addr,
    input  logic              req_write,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [15:0]       cfg_data,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [1:0]        dec_target,
    output logic              dec_rom_write,
    output logic [35:0]       dec_offset
);
    typedef struct packed {
        logic              valid;
        target_e           target;
        logic              rom_write;
        logic [ADDR_W-1:0] offset;
    } decision_t;

    decision_t out_d, out_q;

    logic [NUM_SEG-1:0] rd_en, wr_en;
    logic [SZ_W-1:0]    low_mb, high_mb;
    target_e            nxt_target;
    logic               nxt_rom_write;
    logic [ADDR_W-1:0]  nxt_offset;
    logic               accept;

    shadow_cfg_regs #(.NUM_SEG(NUM_SEG), .SZ_W(SZ_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .rd_en(rd_en), .wr_en(wr_en),
        .low_mb(low_mb), .high_mb(high_mb)
    );

    shadow_region_decode #(.NUM_SEG(NUM_SEG), .SZ_W(SZ_W)) u_dec (
        .addr(req_addr), .write(req_write), .rd_en(rd_en), .wr_en(wr_en),
        .low_mb(low_mb), .high_mb(high_mb), .target(nxt_target),
        .rom_write(nxt_rom_write), .offset(nxt_offset)
    );

    assign req_ready = !out_q.valid || dec_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        out_d = out_q;
        if (out_q.valid && dec_ready) out_d.valid = 1'b0;
        if (accept) begin
            out_d.valid     = 1'b1;
            out_d.target    = nxt_target;
            out_d.rom_write = nxt_rom_write;
            out_d.offset    = nxt_offset;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dec_valid     = out_q.valid;
    assign dec_target    = out_q.target;
    assign dec_rom_write = out_q.rom_write;
    assign dec_offset    = out_q.offset;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_target)
            && $stable(dec_offset) && $stable(dec_rom_write)));

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> dec_valid);

    assert_low_ram_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_addr < HOLE_BASE)
            |=> (dec_target == 2'd1 && dec_offset == $past(req_addr)));

    assert_hole_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_addr >= HOLE_BASE && req_addr < SHADOW_BASE)
            |=> (dec_target == 2'd0));

    assert_rom_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> !dec_rom_write);

    assert_reset_idle_R8: assert property (@(posedge clk)
        !rst_n |=> !dec_valid);
endmodule

// File: tb/shadow_router_tb.sv
module shadow_router_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_write = 0, cfg_we = 0, dec_ready = 1;
    logic [35:0] req_addr = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic        req_ready, dec_valid, dec_rom_write;
    logic [1:0]  dec_target;
    logic [35:0] dec_offset;

    int checks = 0, errors = 0, cyc = 0;
    bit stall_mode = 0, done = 0;

    // reference model state
    bit      exp_valid = 0, exp_rom = 0;
    int      exp_tgt = 0;
    longint  exp_off = 0;
    string   exp_tag = "R8";
    longint  m_re = 0, m_we = 0, m_low = 0, m_high = 0;

    shadow_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .dec_valid(dec_valid),
        .dec_ready(dec_ready), .dec_target(dec_target),
        .dec_rom_write(dec_rom_write), .dec_offset(dec_offset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic model(input longint a, input bit wr,
                         output int tgt, output bit rom, output longint off, output string tag);
        longint low_lim, seg;
        bit en;
        low_lim = (m_low > 4096) ? 4096 : m_low;
        tgt = 0; rom = 0; off = 0;
        if (a < 'hA0000) begin tgt = 1; off = a; tag = "R1"; end
        else if (a < 'hC0000) tag = "R2";
        else if (a < 'h100000) begin
            seg = (a < 'hF0000) ? (a - 'hC0000) / 'h4000 : 12;
            en = wr ? m_we[seg] : m_re[seg];
            if (en) begin tgt = 1; off = a; end
            else begin tgt = 2; rom = wr; end
            tag = (wr && !en) ? "R4" : "R3";
        end else if (a < 64'h1_0000_0000) begin
            if (a < low_lim * 1048576) begin tgt = 1; off = a; tag = "R5"; end
            else tag = "R7";
        end else if (a < 64'h1_0000_0000 + m_high * 1048576) begin
            tgt = 1; off = low_lim * 1048576 + a - 64'h1_0000_0000; tag = "R6";
        end else tag = "R7";
    endtask

    always @(posedge clk) begin
        int t; bit r; longint o; string g;
        cyc++;
        if (!rst_n) begin
            exp_valid = 0; m_re = 0; m_we = 0; m_low = 0; m_high = 0;
        end else begin
            if (req_valid && (!exp_valid || dec_ready)) begin
                model(longint'(req_addr), req_write, t, r, o, g);
                exp_valid = 1; exp_tgt = t; exp_rom = r; exp_off = o;
                exp_tag = cfg_we ? "R10" : g;
            end else if (dec_ready) exp_valid = 0;
            if (cfg_we) case (cfg_sel)
                2'd0: m_re = longint'(cfg_data[12:0]);
                2'd1: m_we = longint'(cfg_data[12:0]);
                2'd2: m_low = longint'(cfg_data);
                default: m_high = longint'(cfg_data);
            endcase
        end
    end

    always @(negedge clk) dec_ready <= stall_mode ? (cyc % 3 == 0) : 1'b1;

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            checks++;
            if (req_ready !== (!exp_valid || dec_ready)) begin
                errors++;
                $display("FAIL R9 req_ready actual %b expected %b", req_ready, !exp_valid || dec_ready);
            end
            checks++;
            if (dec_valid !== exp_valid) begin
                errors++;
                $display("FAIL R9 dec_valid actual %b expected %b", dec_valid, exp_valid);
            end else if (exp_valid) begin
                checks++;
                if (dec_target !== 2'(exp_tgt) || dec_rom_write !== exp_rom
                    || dec_offset !== 36'(exp_off)) begin
                    errors++;
                    $display("FAIL %s actual tgt=%0d rom=%b off=%h expected tgt=%0d rom=%b off=%h",
                             exp_tag, dec_target, dec_rom_write, dec_offset,
                             exp_tgt, exp_rom, 36'(exp_off));
                end
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_data = data;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic send(input logic [35:0] a, input bit wr);
        bit r;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = wr;
        #1;
        do begin
            r = req_ready;
            @(negedge clk);
            #1;
        end while (!r);
        req_valid = 0;
    endtask

    task automatic sweep_shadow();
        for (int i = 0; i < 13; i++) begin
            logic [35:0] a;
            a = (i < 12) ? 36'hC0000 + 36'(i) * 36'h4000 + 36'h123 : 36'hFABCD;
            send(a, 0);
            send(a, 1);
        end
        send(36'hEFFFF, 0);
        send(36'hF0000, 1);
    endtask

    task automatic sweep_ranges();
        send(36'h0, 0); send(36'h9FFFF, 1);                     // R1
        send(36'hA0000, 0); send(36'hBFFFF, 1);                 // R2
        send(36'h100000, 0); send(36'h1FFFFFFF, 1);             // R5
        send(36'h20000000, 0); send(36'hFFF00000, 0);           // R7
        send(36'h1_0000_0000, 0); send(36'h1_3FFF_FFFF, 1);     // R6
        send(36'h1_4000_0000, 0); send(36'hF_FFFF_FFFF, 1);     // R7
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R8: reset state
        checks++;
        if (dec_valid !== 1'b0) begin
            errors++; $display("FAIL R8 dec_valid actual %b expected 0", dec_valid);
        end
        rst_n = 1;
        // R8: cleared enables route the shadow window to ROM, zero sizes unclaim extended memory
        sweep_shadow();
        send(36'h100000, 0);
        cfg_write(2, 16'd512);
        cfg_write(3, 16'd1024);
        sweep_ranges();
        cfg_write(0, 16'h0AAA); cfg_write(1, 16'h1555);
        sweep_shadow();
        cfg_write(0, 16'h1555); cfg_write(1, 16'h0AAA);
        sweep_shadow();
        cfg_write(0, 16'h1FFF); cfg_write(1, 16'h1FFF);
        sweep_shadow();
        cfg_write(2, 16'd6000);                                 // R5/R6 clamp of low size
        send(36'hFFFFFFFF, 0); send(36'h1_0000_0010, 0);
        cfg_write(2, 16'd512);
        // R9: stalled consumer
        stall_mode = 1;
        sweep_ranges();
        cfg_write(0, 16'h0F0F); cfg_write(1, 16'h10F0);
        sweep_shadow();
        stall_mode = 0;
        // R10: configuration write in the same cycle as a request
        cfg_write(0, 16'h0000);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 0; cfg_data = 16'h0001;
        req_valid = 1; req_addr = 36'hC0010; req_write = 0;
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        send(36'hC0010, 0);
        repeat (4) @(negedge clk);
        done = 1;
    end

    initial begin
        while (!done && cyc < 100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R9 watchdog actual hung expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule